// File: doc/BRIEF.md
# ATAPI Command Register Handshake

This block is the drive-side piece of an ATAPI task file that carries a command byte from the host to a local control processor. The host side writes three registers: the command byte, the drive/head select byte and the device control byte. The processor side reads those registers back and programs a transfer control byte. One bit of the transfer control byte holds the local drive number. The processor also sees two flags: a command interrupt and a soft-reset interrupt. Alongside them it sees a busy status.

Before taking a command, the block decides whether this drive is the one the host is addressing. It compares the drive bit of the drive/head select byte with the local drive number. A command for this drive is latched and raises the command interrupt and busy. The diagnostic opcode 90h is always latched and always raises them, whichever drive is addressed. Any other command aimed at the other drive is dropped. The interrupt flags clear as a side effect of the processor reading the matching register. Busy drops only when the processor writes to the command address, which acts as a release strobe.

The handshake is a three-state machine. The states are HS_IDLE (no command outstanding), HS_PEND (interrupt and busy set) and HS_BUSY (interrupt taken, busy still set). Its transitions are:

- ACCEPT: any state goes to HS_PEND on an accepted command.
- TAKE: HS_PEND goes to HS_BUSY on a processor read of the command register.
- RELEASE: HS_BUSY goes to HS_IDLE on the release strobe.

Every other input leaves the state unchanged.

Top module: `atapi_cmd_hs`

## Requirements
- R1: The processor reads, at processor address 0, the last command byte the block accepted from the host at host address 0.
- R2: The drive is selected when bit 4 of the drive/head select byte (host address 1) equals bit 0 of the transfer control byte (processor address 3, read/write). The selection follows both bytes at every write.
- R3: A host command write while the drive is selected sets cmd_irq and stores the byte, both visible on the cycle after the write.
- R4: A host command write of 90h sets cmd_irq and stores the byte even when the drive is not selected.
- R5: busy rises with every accepted command and is high in every cycle that cmd_irq is high.
- R6: A processor read at address 0 while cmd_irq is high clears cmd_irq on the next cycle, and busy stays high.
- R7: A processor write at address 0 clears busy only when cmd_irq is low and no command is accepted in the same cycle. Otherwise the write has no effect.
- R8: After reset the transfer control byte reads 01h, the command and device control bytes read 00h, and cmd_irq, busy and srst_irq are low.
- R9: srst_irq is set when the host writes the device control byte (host address 2) with bit 2 going from 0 to 1. A processor read at address 2 clears it; a set in the same cycle wins.
- R10: A processor read of the drive/head select byte (address 1) returns bits 7 to 5 as 1 and bits 4 to 0 as written by the host.
- R11: A host command write of any byte other than 90h while the drive is not selected changes neither the stored command nor any flag.
- R12: When an accepted host command write and a processor read of address 0 fall in the same cycle, cmd_irq stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 2 | Host register address (0 command, 1 drive/head, 2 device control) |
| h_wdata | input | 8 | Host write data |
| p_rd | input | 1 | Processor read strobe |
| p_wr | input | 1 | Processor write strobe |
| p_addr | input | 2 | Processor register address (0 command, 1 drive/head, 2 device control, 3 transfer control) |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data, combinational from p_addr |
| cmd_irq | output | 1 | Command interrupt flag |
| busy | output | 1 | Busy status |
| srst_irq | output | 1 | Soft-reset interrupt flag |

## Verification
The bench sends host commands under four conditions: selected, not selected, the diagnostic opcode, and an ordinary opcode. Comparing these separates the selection rule from the diagnostic exception. The local drive number is switched at random, which tests that selection tracks both bytes rather than one. Processor reads and release strobes land in every handshake state, which separates read-to-clear from strobe-to-clear. Same-cycle collisions check which input wins. Device control writes are repeated with bit 2 held high, which separates edge-triggered setting from level-triggered setting.

// File: rtl/tf_cmd_pkg.sv
package tf_cmd_pkg;
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_PEND = 2'd1,
        HS_BUSY = 2'd2
    } hs_state_t;

    localparam logic [1:0] RA_CMD    = 2'd0;
    localparam logic [1:0] RA_DRVSEL = 2'd1;
    localparam logic [1:0] RA_DEVCTL = 2'd2;
    localparam logic [1:0] RA_XFER   = 2'd3;
endpackage

// File: rtl/tf_drive_select.sv
module tf_drive_select #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] DIAG = 8'h90
) (
    input  logic          host_drv,
    input  logic          local_drv,
    input  logic          cmd_wr,
    input  logic [DW-1:0] cmd_byte,
    output logic          selected,
    output logic          accept
);
    logic is_diag;

    always_comb begin
        selected = (host_drv == local_drv);
        is_diag  = (cmd_byte == DIAG);
        accept   = cmd_wr && (selected || is_diag);
    end
endmodule

// File: rtl/tf_cmd_fsm.sv
module tf_cmd_fsm
    import tf_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic cmd_rd,
    input  logic rel_strobe,
    output logic cmd_irq,
    output logic busy
);
    hs_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (accept) state_d = HS_PEND;
            HS_PEND: begin
                if (accept)      state_d = HS_PEND;
                else if (cmd_rd) state_d = HS_BUSY;
            end
            HS_BUSY: begin
                if (accept)          state_d = HS_PEND;
                else if (rel_strobe) state_d = HS_IDLE;
            end
            default: state_d = HS_IDLE;
        endcase
    end

    always_comb begin
        cmd_irq = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            HS_IDLE: ;
            HS_PEND: begin cmd_irq = 1'b1; busy = 1'b1; end
            HS_BUSY: busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tf_regs.sv
module tf_regs
    import tf_cmd_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DRV_BIT  = 4,
    parameter int LOC_BIT  = 0,
    parameter int SRST_BIT = 2,
    parameter int PAD_LO   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic [1:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          accept,
    input  logic          p_rd,
    input  logic          p_wr,
    input  logic [1:0]    p_addr,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata,
    output logic [DW-1:0] cmd_q,
    output logic          host_drv,
    output logic          local_drv,
    output logic          srst_irq
);
    localparam logic [DW-1:0] XFER_RST = {{(DW-1){1'b0}}, 1'b1} << LOC_BIT;

    logic [PAD_LO-1:0] drvsel_q;
    logic [DW-1:0]     devctl_q;
    logic [DW-1:0]     xfer_q;
    logic [DW-1:0]     drvsel_rd;
    logic              srst_set, srst_clr;

    for (genvar i = 0; i < DW; i++) begin : g_pad
        if (i >= PAD_LO) begin : g_one
            assign drvsel_rd[i] = 1'b1;
        end else begin : g_keep
            assign drvsel_rd[i] = drvsel_q[i];
        end
    end

    always_comb begin
        srst_set = h_wr && (h_addr == RA_DEVCTL) && h_wdata[SRST_BIT] && !devctl_q[SRST_BIT];
        srst_clr = p_rd && (p_addr == RA_DEVCTL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            drvsel_q <= '0;
            devctl_q <= '0;
            xfer_q   <= XFER_RST;
            srst_irq <= 1'b0;
        end else begin
            if (accept) cmd_q <= h_wdata;
            if (h_wr && h_addr == RA_DRVSEL) drvsel_q <= h_wdata[PAD_LO-1:0];
            if (h_wr && h_addr == RA_DEVCTL) devctl_q <= h_wdata;
            if (p_wr && p_addr == RA_XFER) xfer_q <= p_wdata;
            if (srst_set)      srst_irq <= 1'b1;
            else if (srst_clr) srst_irq <= 1'b0;
        end
    end

    always_comb begin
        host_drv  = drvsel_q[DRV_BIT];
        local_drv = xfer_q[LOC_BIT];
        unique case (p_addr)
            RA_CMD:    p_rdata = cmd_q;
            RA_DRVSEL: p_rdata = drvsel_rd;
            RA_DEVCTL: p_rdata = devctl_q;
            default:   p_rdata = xfer_q;
        endcase
    end
endmodule

// File: rtl/atapi_cmd_hs.sv
module atapi_cmd_hs
    import tf_cmd_pkg::*;
#(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] DIAG = 8'h90
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic [1:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          p_rd,
    input  logic          p_wr,
    input  logic [1:0]    p_addr,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata,
    output logic          cmd_irq,
    output logic          busy,
    output logic          srst_irq
);
    logic          selected, accept, host_drv, local_drv;
    logic          cmd_wr, cmd_rd, rel_strobe;
    logic [DW-1:0] cmd_q;

    assign cmd_wr     = h_wr && (h_addr == RA_CMD);
    assign cmd_rd     = p_rd && (p_addr == RA_CMD);
    assign rel_strobe = p_wr && (p_addr == RA_CMD);

    tf_drive_select #(.DW(DW), .DIAG(DIAG)) u_sel (
        .host_drv(host_drv), .local_drv(local_drv), .cmd_wr(cmd_wr),
        .cmd_byte(h_wdata), .selected(selected), .accept(accept)
    );

    tf_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_rd(cmd_rd),
        .rel_strobe(rel_strobe), .cmd_irq(cmd_irq), .busy(busy)
    );

    tf_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .accept(accept), .p_rd(p_rd), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata),
        .p_rdata(p_rdata), .cmd_q(cmd_q), .host_drv(host_drv), .local_drv(local_drv),
        .srst_irq(srst_irq)
    );
endmodule

// File: rtl/atapi_cmd_hs_chk.sv
module atapi_cmd_hs_chk #(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] DIAG = 8'h90
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_wr,
    input logic [1:0]    h_addr,
    input logic [DW-1:0] h_wdata,
    input logic          p_rd,
    input logic [1:0]    p_addr,
    input logic          cmd_irq,
    input logic          busy,
    input logic          srst_irq,
    input logic          selected,
    input logic [DW-1:0] cmd_q
);
    logic hcmd, taken;
    assign hcmd  = h_wr && (h_addr == 2'd0);
    assign taken = hcmd && (selected || h_wdata == DIAG);

    // R5
    irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq |-> busy);

    // R4
    diag_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd && h_wdata == DIAG) |=> (cmd_irq && cmd_q == DIAG));

    // R3
    sel_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd && selected) |=> (cmd_irq && cmd_q == $past(h_wdata)));

    // R11
    unsel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcmd && !selected && h_wdata != DIAG && !cmd_irq) |=> (!cmd_irq && $stable(cmd_q)));

    // R6
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rd && p_addr == 2'd0 && cmd_irq && !taken) |=> (!cmd_irq && busy));

    // R12
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rd && p_addr == 2'd0 && taken) |=> cmd_irq);

    // R9
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rd && p_addr == 2'd2 && !(h_wr && h_addr == 2'd2)) |=> !srst_irq);
endmodule

bind atapi_cmd_hs atapi_cmd_hs_chk #(.DW(DW), .DIAG(DIAG)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .p_rd(p_rd), .p_addr(p_addr), .cmd_irq(cmd_irq), .busy(busy),
    .srst_irq(srst_irq), .selected(selected), .cmd_q(cmd_q)
);

// File: tb/atapi_cmd_hs_tb_top.sv
module atapi_cmd_hs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
    logic [1:0] h_addr = '0, p_addr = '0;
    logic [7:0] h_wdata = '0, p_wdata = '0;
    logic [7:0] p_rdata;
    logic       cmd_irq, busy, srst_irq;

    int n_chk = 0;
    int n_bad = 0;

    // independent model of the requirements
    logic [7:0] m_cmd, m_drv, m_dev, m_xfer;
    logic       m_irq, m_busy, m_srst;

    always #5 clk = ~clk;

    atapi_cmd_hs dut_i (
        .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .p_rd(p_rd), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata),
        .p_rdata(p_rdata), .cmd_irq(cmd_irq), .busy(busy), .srst_irq(srst_irq)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmd;                       // R1
            2'd1:    return {3'b111, m_drv[4:0]};        // R10
            2'd2:    return m_dev;
            default: return m_xfer;
        endcase
    endfunction

    task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cmd = 8'h00; m_drv = 8'h00; m_dev = 8'h00; m_xfer = 8'h01;
        m_irq = 1'b0; m_busy = 1'b0; m_srst = 1'b0;
    endtask

    // one clock of stimulus; called just after a falling edge
    task automatic step(input logic hw, input logic [1:0] ha, input logic [7:0] hd,
                        input logic pr, input logic pw, input logic [1:0] pa, input logic [7:0] pd);
        logic acc;
        logic srst_set;
        h_wr = hw; h_addr = ha; h_wdata = hd;
        p_rd = pr; p_wr = pw; p_addr = pa; p_wdata = pd;
        #1;
        if (pr) cmp((pa == 2'd1) ? "R10" : "R1", p_rdata, exp_read(pa));
        // R2 selection, R4 diagnostic exception, R11 drop
        acc = hw && ha == 2'd0 && (hd == 8'h90 || m_drv[4] == m_xfer[0]);
        srst_set = hw && ha == 2'd2 && hd[2] && !m_dev[2];
        if (acc) begin m_irq = 1'b1; m_busy = 1'b1; m_cmd = hd; end      // R3 R5 R12
        else if (m_irq && pr && pa == 2'd0) m_irq = 1'b0;                // R6
        else if (!m_irq && m_busy && pw && pa == 2'd0) m_busy = 1'b0;    // R7
        if (srst_set) m_srst = 1'b1;
        else if (pr && pa == 2'd2) m_srst = 1'b0;                        // R9
        if (hw && ha == 2'd1) m_drv = hd;
        if (hw && ha == 2'd2) m_dev = hd;
        if (pw && pa == 2'd3) m_xfer = pd;
        @(negedge clk);
        cmp("R3", {7'd0, cmd_irq}, {7'd0, m_irq});
        cmp("R5/R7", {7'd0, busy}, {7'd0, m_busy});
        cmp("R9", {7'd0, srst_irq}, {7'd0, m_srst});
    endtask

    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        step(1'b1, a, d, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask
    task automatic prd(input logic [1:0] a);
        step(1'b0, 2'd0, 8'h00, 1'b1, 1'b0, a, 8'h00);
    endtask
    task automatic pwr(input logic [1:0] a, input logic [7:0] d);
        step(1'b0, 2'd0, 8'h00, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        cmp("R8", {5'd0, cmd_irq, busy, srst_irq}, 8'h00);
        prd(2'd3); prd(2'd0); prd(2'd2); prd(2'd1);
        cmp("R8", p_rdata, 8'hE0);

        // R11: not selected (drive bit 0, local 1), ordinary opcode dropped
        hwr(2'd0, 8'hA0);
        prd(2'd0);
        // R4: diagnostic always taken
        hwr(2'd0, 8'h90);
        pwr(2'd0, 8'h00);          // R7: strobe ignored while interrupt pending
        prd(2'd0);                 // R6: read clears interrupt, busy stays
        pwr(2'd0, 8'h00);          // R7: release
        // R2: select by drive bit
        hwr(2'd1, 8'h10);
        prd(2'd1);                 // R10
        hwr(2'd0, 8'hA0);          // R3
        step(1'b1, 2'd0, 8'h4A, 1'b1, 1'b0, 2'd0, 8'h00); // R12 collision
        prd(2'd0);
        // R2: change local drive number to 0, now deselected
        pwr(2'd3, 8'h00);
        hwr(2'd0, 8'h12);          // R11
        prd(2'd0);
        pwr(2'd0, 8'h00);
        // R9: edge-set soft reset flag
        hwr(2'd2, 8'h04);
        prd(2'd2);
        hwr(2'd2, 8'h04);          // level held, no new set
        hwr(2'd2, 8'h00);
        step(1'b1, 2'd2, 8'h04, 1'b1, 1'b0, 2'd2, 8'h00); // set wins over clear

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] ha, pa;
            logic [7:0] hd, pd;
            logic       hw, pr, pw;
            hw = ($urandom % 3) != 0;
            ha = 2'($urandom % 4);
            hd = (($urandom % 4) == 0) ? 8'h90 : 8'($urandom);
            pr = ($urandom % 3) == 0;
            pw = ($urandom % 4) == 0;
            pa = 2'($urandom % 4);
            pd = 8'($urandom);
            step(hw, ha, hd, pr, pw, pa, pd);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule